// File: doc/BRIEF.md
# MIDI Note and Bend to Pulse-Width Control Voltage Converter

This block sits behind a serial byte receiver and turns a stream of MIDI bytes into three control values: a pitch code, a gate level and a pitch-bend code. Each byte arrives on an 8-bit bus together with a one-cycle valid strobe. The block follows running status. It reacts to note-on, note-off and pitch-bend messages on one receive channel, which is fixed by a parameter. It consumes every other message type without any effect on its outputs.

The pitch code covers five octaves in steps of 4 counts per semitone, from 0 to 240. Two pulse-width generators share a 240-count period. One turns the pitch code into a duty cycle and the other does the same for the bend code. An external low-pass filter then gives a 1 V/octave voltage and a bend voltage. A new compare value is taken into a generator only when its counter wraps, so no period is ever cut short or stretched.

Top module: `midi_cv_core`

## Requirements
- R1: After reset, pitch_code is 0, gate is 0 and bend_code is 0. Both pulse outputs stay low until a nonzero code has been loaded at a counter wrap.
- R2: A byte of 0xF8 or above has no effect on any output or on the parser. This holds even between the two data bytes of a message.
- R3: A status byte is accepted when all three of these hold: its upper nibble is 0x8 (note-off), 0x9 (note-on) or 0xE (pitch-bend); its lower nibble equals the CHANNEL parameter (default 0); and it is below 0xF8. Any other status byte below 0xF8, including 0xF0 to 0xF7, clears the running status. The data bytes that follow it then change nothing.
- R4: A data byte (bit 7 clear) changes nothing while the running status is zero. The running status is zero at reset.
- R5: An accepted status is kept as the running status. After it, bytes are taken in pairs: first the note or unused byte, then the velocity or value byte. Each further pair without a new status byte acts as a complete message of the same kind.
- R6: For note messages, pitch_code = 4 × (min(max(note, 36), 96) − 36), which gives 0 to 240.
- R7: A note-on with nonzero velocity sets gate to 1. A note-on with velocity 0 and a note-off both set gate to 0. Both message kinds update pitch_code.
- R8: For pitch-bend, bend_code = 2 × (min(max(value, 4), 119) − 4), where value is the second data byte. This gives 0 to 230. The first data byte is ignored.
- R9: The outputs of a message change in the clock cycle after the cycle in which its second data byte is strobed. They hold steady in every cycle with no strobe.
- R10: Each pulse output is high while a shared counter, which runs 0 to 239 and wraps, is below that output's compare value. A compare value reloads from its code only in the cycle the counter wraps. Once a code has been steady for a full period, any 240 consecutive cycles show exactly code high cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | One-cycle strobe marking a received byte |
| rx_byte | input | 8 | Received MIDI byte |
| pitch_code | output | 8 | Registered pitch code, 0 to 240 |
| gate | output | 1 | Note gate level |
| bend_code | output | 8 | Registered pitch-bend code, 0 to 230 |
| pitch_pwm | output | 1 | Pulse-width output for the pitch code |
| bend_pwm | output | 1 | Pulse-width output for the bend code |

## Verification
The bench places real-time bytes between the two data bytes of a message. A parser that reset its pair position on those bytes would take the velocity as a note. The bench also sends notes just inside and just outside both clamp limits, and bend values at 3, 4, 119 and 127, so an off-by-one limit or a missing offset shows up as a wrong code. It sends statuses for a foreign channel, a controller and system common messages, each followed by data. A design that kept the old running status would move the pitch or the gate on those data bytes. Finally, it counts high cycles over whole periods at codes 0, 96, 230 and 240, which catches a wrong wrap point or a compare that reloads in mid-period.

// File: rtl/midi_cv_core.sv
module midi_cv_core #(
  parameter logic [3:0] CHANNEL    = 4'd0,
  parameter int         PWM_PERIOD = 240,
  parameter int         LOW_NOTE   = 36,
  parameter int         NOTE_SPAN  = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  output logic [7:0] pitch_code,
  output logic       gate,
  output logic [7:0] bend_code,
  output logic       pitch_pwm,
  output logic       bend_pwm
);
  localparam int PWM_TOP  = PWM_PERIOD - 1;
  localparam int HIGH_NOTE = LOW_NOTE + NOTE_SPAN;

  typedef enum logic [1:0] {P_IDLE, P_FIRST, P_SECOND} pstate_t;

  pstate_t    st;
  logic [7:0] run_stat;
  logic [6:0] note_q;
  logic [7:0] pwm_cnt, pitch_cmp, bend_cmp;

  wire is_rt     = rx_valid && (rx_byte >= 8'hF8);
  wire is_stat   = rx_valid && rx_byte[7] && !is_rt;
  wire is_data   = rx_valid && !rx_byte[7];
  wire kind_ok   = (rx_byte[7:4] == 4'h8) || (rx_byte[7:4] == 4'h9) || (rx_byte[7:4] == 4'hE);
  wire stat_ok   = kind_ok && (rx_byte[3:0] == CHANNEL);
  wire msg_done  = is_data && (run_stat != 8'h00) && (st == P_SECOND);
  wire kind_note = (run_stat[7:4] == 4'h8) || (run_stat[7:4] == 4'h9);
  wire kind_bend = (run_stat[7:4] == 4'hE);

  logic [7:0] note_off, pitch_next, val_clamp, bend_next;
  always_comb begin
    if (note_q < 7'(LOW_NOTE))       note_off = 8'd0;
    else if (note_q > 7'(HIGH_NOTE)) note_off = 8'(NOTE_SPAN);
    else                             note_off = 8'(note_q) - 8'(LOW_NOTE);
    pitch_next = {note_off[5:0], 2'b00};
    if (rx_byte < 8'd4)        val_clamp = 8'd4;
    else if (rx_byte > 8'd119) val_clamp = 8'd119;
    else                       val_clamp = rx_byte;
    bend_next = {val_clamp - 8'd4, 1'b0} [7:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= P_IDLE;
      run_stat   <= 8'h00;
      note_q     <= 7'd0;
      pitch_code <= 8'd0;
      gate       <= 1'b0;
      bend_code  <= 8'd0;
    end else if (is_stat) begin
      run_stat <= stat_ok ? rx_byte : 8'h00;
      st       <= stat_ok ? P_FIRST : P_IDLE;
    end else if (is_data && run_stat != 8'h00) begin
      if (st == P_FIRST) begin
        note_q <= rx_byte[6:0];
        st     <= P_SECOND;
      end else if (msg_done) begin
        st <= P_FIRST;
        if (kind_note) begin
          pitch_code <= pitch_next;
          gate       <= (run_stat[7:4] == 4'h9) && (rx_byte != 8'd0);
        end
        if (kind_bend) bend_code <= bend_next;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwm_cnt   <= 8'd0;
      pitch_cmp <= 8'd0;
      bend_cmp  <= 8'd0;
    end else if (pwm_cnt == 8'(PWM_TOP)) begin
      pwm_cnt   <= 8'd0;
      pitch_cmp <= pitch_code;
      bend_cmp  <= bend_code;
    end else begin
      pwm_cnt <= pwm_cnt + 8'd1;
    end
  end

  assign pitch_pwm = pwm_cnt < pitch_cmp;
  assign bend_pwm  = pwm_cnt < bend_cmp;
endmodule

// File: rtl/midi_cv_core_chk.sv
module midi_cv_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_valid,
  input logic [7:0] rx_byte,
  input logic [7:0] pitch_code,
  input logic       gate,
  input logic [7:0] bend_code,
  input logic [7:0] pwm_cnt,
  input logic [7:0] pitch_cmp,
  input logic [7:0] bend_cmp
);
  assert_realtime_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_byte >= 8'hF8) |=> ($stable(pitch_code) && $stable(gate) && $stable(bend_code)));

  assert_pitch_grid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pitch_code <= 8'd240) && (pitch_code[1:0] == 2'b00));

  assert_bend_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bend_code <= 8'd230) && !bend_code[0]);

  assert_quiet_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> ($stable(pitch_code) && $stable(gate) && $stable(bend_code)));

  assert_cmp_at_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_cnt != 8'd239) |=> ($stable(pitch_cmp) && $stable(bend_cmp)));

  assert_cnt_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_cnt < 8'd240);
endmodule

bind midi_cv_core midi_cv_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
  .pitch_code(pitch_code), .gate(gate), .bend_code(bend_code),
  .pwm_cnt(pwm_cnt), .pitch_cmp(pitch_cmp), .bend_cmp(bend_cmp)
);

// File: tb/midi_cv_core_tb.sv
module midi_cv_core_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic [7:0] pitch_code, bend_code;
  logic       gate, pitch_pwm, bend_pwm;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_req = "R1";

  midi_cv_core u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .pitch_code(pitch_code), .gate(gate), .bend_code(bend_code),
    .pitch_pwm(pitch_pwm), .bend_pwm(bend_pwm)
  );

  always #4 clk = ~clk;

  int m_rs, m_st, m_note, m_pitch, m_gate, m_bend, m_cnt, m_pcmp, m_bcmp;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rs = 0; m_st = 0; m_note = 0; m_pitch = 0; m_gate = 0; m_bend = 0;
      m_cnt = 0; m_pcmp = 0; m_bcmp = 0;
    end else begin
      if (m_cnt == 239) begin
        m_cnt = 0; m_pcmp = m_pitch; m_bcmp = m_bend;
      end else m_cnt++;
      if (rx_valid) begin
        int b;
        b = rx_byte;
        if (b >= 248) begin
        end else if (b >= 128) begin
          if (((b / 16) == 8 || (b / 16) == 9 || (b / 16) == 14) && (b % 16) == 0) begin
            m_rs = b; m_st = 1;
          end else begin
            m_rs = 0; m_st = 0;
          end
        end else if (m_rs != 0) begin
          if (m_st == 1) begin
            m_note = b; m_st = 2;
          end else if (m_st == 2) begin
            m_st = 1;
            if (m_rs == 128 || m_rs == 144) begin
              int n;
              n = (m_note < 36) ? 36 : m_note;
              n = n - 36;
              if (n > 60) n = 60;
              m_pitch = n * 4;
              m_gate = (m_rs == 144 && b != 0) ? 1 : 0;
            end
            if (m_rs == 224) begin
              int v;
              v = (b < 4) ? 4 : (b > 119) ? 119 : b;
              m_bend = (v - 4) * 2;
            end
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (pitch_code !== 8'(m_pitch) || gate !== 1'(m_gate) || bend_code !== 8'(m_bend)
          || pitch_pwm !== (m_cnt < m_pcmp) || bend_pwm !== (m_cnt < m_bcmp)) begin
        errors++;
        $display("FAIL %s model: actual p=%0d g=%0d b=%0d pp=%0d bp=%0d expected p=%0d g=%0d b=%0d pp=%0d bp=%0d",
                 cur_req, pitch_code, gate, bend_code, pitch_pwm, bend_pwm,
                 m_pitch, m_gate, m_bend, m_cnt < m_pcmp, m_cnt < m_bcmp);
      end
    end
  end

  task automatic send(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(negedge clk); rx_valid = 1'b0; rx_byte = 8'h00;
  endtask

  task automatic expect_out(input string req, input int p, input int g, input int bc);
    checks++;
    if (pitch_code !== 8'(p) || gate !== 1'(g) || bend_code !== 8'(bc)) begin
      errors++;
      $display("FAIL %s: actual p=%0d g=%0d b=%0d expected p=%0d g=%0d b=%0d",
               req, pitch_code, gate, bend_code, p, g, bc);
    end
  endtask

  task automatic duty(input string req, input bit which, input int exp);
    int hi = 0;
    repeat (260) @(negedge clk);
    for (int i = 0; i < 240; i++) begin
      @(negedge clk);
      hi += which ? int'(bend_pwm) : int'(pitch_pwm);
    end
    checks++;
    if (hi != exp) begin
      errors++;
      $display("FAIL %s duty: actual %0d expected %0d", req, hi, exp);
    end
  endtask

  initial begin
    #1600000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_out("R1", 0, 0, 0);
    checks++;
    if (pitch_pwm !== 1'b0 || bend_pwm !== 1'b0) begin
      errors++;
      $display("FAIL R1: actual pwm %0d%0d expected 00", pitch_pwm, bend_pwm);
    end

    cur_req = "R4";
    send(8'd60); send(8'd100);
    expect_out("R4", 0, 0, 0);

    cur_req = "R7";
    send(8'h90); send(8'd60);
    expect_out("R9", 0, 0, 0);
    send(8'd100);
    expect_out("R7", 96, 1, 0);
    duty("R10", 0, 96);

    cur_req = "R5";
    send(8'd64); send(8'd100);
    expect_out("R5", 112, 1, 0);
    send(8'd64); send(8'd0);
    expect_out("R7", 112, 0, 0);

    cur_req = "R6";
    send(8'h80); send(8'd30); send(8'd64);
    expect_out("R6", 0, 0, 0);
    duty("R10", 0, 0);
    send(8'h90); send(8'd95); send(8'd1);
    expect_out("R6", 236, 1, 0);
    send(8'd96); send(8'd1);
    expect_out("R6", 240, 1, 0);
    send(8'd97); send(8'd1);
    expect_out("R6", 240, 1, 0);
    duty("R10", 0, 240);
    send(8'd36); send(8'd9);
    expect_out("R6", 0, 1, 0);
    send(8'd35); send(8'd9);
    expect_out("R6", 0, 1, 0);
    send(8'h80); send(8'd37); send(8'd9);
    expect_out("R7", 4, 0, 0);

    cur_req = "R2";
    send(8'h90); send(8'd50); send(8'hF8); send(8'hFE); send(8'd70);
    expect_out("R2", 56, 1, 0);
    send(8'hFF); send(8'd52); send(8'hFA); send(8'd70);
    expect_out("R2", 64, 1, 0);

    cur_req = "R3";
    send(8'h91); send(8'd40); send(8'd0);
    expect_out("R3", 64, 1, 0);
    send(8'h90); send(8'hB0); send(8'd40); send(8'd0);
    expect_out("R3", 64, 1, 0);
    send(8'h80); send(8'd40); send(8'hF2); send(8'd0); send(8'd0);
    expect_out("R3", 64, 1, 0);
    send(8'hE1); send(8'd0); send(8'd127);
    expect_out("R3", 64, 1, 0);

    cur_req = "R8";
    send(8'hE0); send(8'd99); send(8'd64);
    expect_out("R8", 64, 1, 120);
    send(8'd0); send(8'd127);
    expect_out("R8", 64, 1, 230);
    duty("R10", 1, 230);
    send(8'd0); send(8'd119);
    expect_out("R8", 64, 1, 230);
    send(8'd0); send(8'd3);
    expect_out("R8", 64, 1, 0);
    send(8'd0); send(8'd4);
    expect_out("R8", 64, 1, 0);
    send(8'd0); send(8'd5);
    expect_out("R8", 64, 1, 2);
    duty("R10", 1, 2);

    repeat (5) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule